// File: doc/BRIEF.md
# HDLC Address Field Filter

This block sits behind the deframer of an HDLC receiver. It watches the first bytes of each received frame and decides whether the frame is addressed to this station. A one-byte address is compared with two terminal values, and the value that matches gives the frame's command or response role. A two-byte address is matched as a pair. The high byte must match one of two service-point values or the fixed group value. The low byte must match one of two terminal values or the broadcast value. Only certain combinations of the two count as a match.

Once the address is resolved, the block posts a registered decision. That decision holds a matched-pair code, a command/response flag and a flag that marks frames for automatic handling. For an accepted frame, the byte after the address comes out on a control-field strobe and every later byte comes out as information-field data. A rejected frame produces no output bytes at all. Each new frame, marked by a start-of-frame strobe on its first byte, clears the previous decision.

Top module: `hdlc_addr_filter`

## Requirements
- R1: `cfg_two_byte`=1 selects a two-byte address field (high byte first, then low byte). `cfg_two_byte`=0 selects a one-byte address field.
- R2: In two-byte mode the high byte matches `cfg_sp1`, `cfg_sp2` or the group value 0xFC. The group value 0xFE matches only when C/R masking is on.
- R3: In two-byte mode the low byte matches `cfg_t1`, `cfg_t2` or the broadcast value 0xFF.
- R4: A two-byte address is accepted only for these pairings, each with its `st_pair` code. If several pairings match, the lowest code wins:
  - SP1/T1 gives 1.
  - SP1/FF gives 2.
  - SP2/T2 gives 3.
  - SP2/FF gives 4.
  - group/T1 or group/T2 gives 5.
  - group/FF gives 6.
- R5: With `cfg_cr_ignore`=1, bit 1 of the high byte is left out of every high-byte comparison. With `cfg_cr_ignore`=0 it takes part. For an accepted two-byte frame, `st_cr` equals bit 1 of the high byte.
- R6: In one-byte mode a byte equal to `cfg_t1` is accepted with `st_pair`=7 and `st_cr`=1 (command). Otherwise, a byte equal to `cfg_t2` is accepted with `st_pair`=7 and `st_cr`=0 (response). Any other byte, 0xFF included, is rejected.
- R7: A rejected frame shows `st_accept`=0, `st_pair`=0, `st_cr`=0 and `st_auto`=0, and none of its bytes appear on `ctl_valid` or `info_valid`.
- R8: `st_auto`=1 only when `cfg_mode`=00 and `st_pair`=1. Every other accepted frame has `st_auto`=0.
- R9: For an accepted frame, the first byte after the address pulses `ctl_valid` with the byte on `ctl_data`. Each later byte pulses `info_valid` with the byte on `info_data`. Each pulse lasts one cycle and comes one cycle after the byte is presented.
- R10: `st_done` and the other status outputs update one cycle after the last address byte is presented. A frame that ends before its address is complete leaves `st_done`=0 and `st_accept`=0.
- R11: A byte with `in_sof`=1 clears all status and starts address matching afresh, even in the middle of a frame.
- R12: Status outputs stay constant from the decision until the next start of frame.
- R13: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_two_byte | input | 1 | 1: two-byte address, 0: one-byte address |
| cfg_cr_ignore | input | 1 | Mask C/R bit (bit 1) of the high byte |
| cfg_mode | input | 2 | 00 automatic, 01 pass-through, others treated as pass-through |
| cfg_sp1 | input | W | Service-point value 1 |
| cfg_sp2 | input | W | Service-point value 2 |
| cfg_t1 | input | W | Terminal value 1 (command in one-byte mode) |
| cfg_t2 | input | W | Terminal value 2 (response in one-byte mode) |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Marks the byte as the first of a frame |
| in_data | input | W | Received byte |
| st_done | output | 1 | Address decision taken for current frame |
| st_accept | output | 1 | Frame accepted |
| st_pair | output | 3 | Matched pairing code |
| st_cr | output | 1 | Command/response indication |
| st_auto | output | 1 | Frame flagged for automatic handling |
| ctl_valid | output | 1 | Control-field byte strobe |
| ctl_data | output | W | Control-field byte |
| info_valid | output | 1 | Information-field byte strobe |
| info_data | output | W | Information-field byte |

## Verification
A phase register stuck in the wrong state shows up right away at the ports. The decision appears one byte too early or too late, or the control byte shows up as information data. This is visible on the cycle after the affected byte. A pairing or priority fault gives a wrong `st_pair` code or a wrong accept the cycle after the low byte. A lost start-of-frame clear lets a stale accept let through the bytes of a later frame, which appear on the forwarding strobes one cycle after they arrive.

// File: rtl/hdlc_addr_pkg.sv
package hdlc_addr_pkg;
  localparam int NREF = 3;

  typedef enum logic [2:0] {
    PAIR_NONE   = 3'd0,
    PAIR_SP1_T1 = 3'd1,
    PAIR_SP1_BC = 3'd2,
    PAIR_SP2_T2 = 3'd3,
    PAIR_SP2_BC = 3'd4,
    PAIR_GRP_T  = 3'd5,
    PAIR_GRP_BC = 3'd6,
    PAIR_ONE    = 3'd7
  } pair_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LO   = 3'd1,
    PH_CTL  = 3'd2,
    PH_INFO = 3'd3,
    PH_DROP = 3'd4
  } phase_e;
endpackage

// File: rtl/hdlc_ref_cmp.sv
module hdlc_ref_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] ref_val,
  input  logic [W-1:0] ign_mask,
  output logic         hit
);
  assign hit = (((data ^ ref_val) & ~ign_mask) == '0);
endmodule

// File: rtl/hdlc_pair_sel.sv
module hdlc_pair_sel
  import hdlc_addr_pkg::*;
(
  input  logic            two_byte,
  input  logic [NREF-1:0] hi_hit,
  input  logic [NREF-1:0] lo_hit,
  output logic            hit,
  output pair_e           code
);
  always_comb begin
    code = PAIR_NONE;
    if (two_byte) begin
      if      (hi_hit[0] && lo_hit[0])               code = PAIR_SP1_T1;
      else if (hi_hit[0] && lo_hit[2])               code = PAIR_SP1_BC;
      else if (hi_hit[1] && lo_hit[1])               code = PAIR_SP2_T2;
      else if (hi_hit[1] && lo_hit[2])               code = PAIR_SP2_BC;
      else if (hi_hit[2] && (lo_hit[0] || lo_hit[1])) code = PAIR_GRP_T;
      else if (hi_hit[2] && lo_hit[2])               code = PAIR_GRP_BC;
    end else if (lo_hit[0] || lo_hit[1]) begin
      code = PAIR_ONE;
    end
    hit = (code != PAIR_NONE);
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_addr_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          CR_BIT    = 1,
  parameter logic [W-1:0] GROUP_VAL = 8'hFC,
  parameter logic [W-1:0] BCAST_VAL = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_two_byte,
  input  logic         cfg_cr_ignore,
  input  logic [1:0]   cfg_mode,
  input  logic [W-1:0] cfg_sp1,
  input  logic [W-1:0] cfg_sp2,
  input  logic [W-1:0] cfg_t1,
  input  logic [W-1:0] cfg_t2,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic [W-1:0] in_data,
  output logic         st_done,
  output logic         st_accept,
  output logic [2:0]   st_pair,
  output logic         st_cr,
  output logic         st_auto,
  output logic         ctl_valid,
  output logic [W-1:0] ctl_data,
  output logic         info_valid,
  output logic [W-1:0] info_data
);
  localparam logic [W-1:0] CR_MASK = W'(1) << CR_BIT;

  // Reference sets: index 0/1 programmable, index 2 fixed.
  logic [W-1:0]    hi_refs [NREF];
  logic [W-1:0]    lo_refs [NREF];
  logic [NREF-1:0] hi_hit, lo_hit;
  logic [W-1:0]    hi_mask;
  logic            sel_hit;
  pair_e           sel_code;

  phase_e       phase_q, phase_n;
  logic [W-1:0] hi_q, hi_n;
  logic         done_q, done_n, acc_q, acc_n, cr_q, cr_n, auto_q, auto_n;
  pair_e        pair_q, pair_n;
  logic         ctlv_q, ctlv_n, infov_q, infov_n;
  logic [W-1:0] dat_q, dat_n;
  logic         decide;

  assign hi_refs[0] = cfg_sp1;
  assign hi_refs[1] = cfg_sp2;
  assign hi_refs[2] = GROUP_VAL;
  assign lo_refs[0] = cfg_t1;
  assign lo_refs[1] = cfg_t2;
  assign lo_refs[2] = BCAST_VAL;
  assign hi_mask    = cfg_cr_ignore ? CR_MASK : '0;

  // High side works on the stored first byte; low side on the live byte,
  // which is the only address byte in one-byte mode.
  for (genvar g = 0; g < NREF; g++) begin : g_cmp
    hdlc_ref_cmp #(.W(W)) u_hi (
      .data(hi_q), .ref_val(hi_refs[g]), .ign_mask(hi_mask), .hit(hi_hit[g])
    );
    hdlc_ref_cmp #(.W(W)) u_lo (
      .data(in_data), .ref_val(lo_refs[g]), .ign_mask('0), .hit(lo_hit[g])
    );
  end

  hdlc_pair_sel u_sel (
    .two_byte(cfg_two_byte), .hi_hit(hi_hit), .lo_hit(lo_hit),
    .hit(sel_hit), .code(sel_code)
  );

  always_comb begin
    phase_n = phase_q;
    hi_n    = hi_q;
    done_n  = done_q;
    acc_n   = acc_q;
    pair_n  = pair_q;
    cr_n    = cr_q;
    auto_n  = auto_q;
    ctlv_n  = 1'b0;
    infov_n = 1'b0;
    dat_n   = dat_q;
    decide  = 1'b0;
    if (in_valid) begin
      dat_n = in_data;
      if (in_sof) begin
        done_n = 1'b0;
        acc_n  = 1'b0;
        pair_n = PAIR_NONE;
        cr_n   = 1'b0;
        auto_n = 1'b0;
        if (cfg_two_byte) begin
          hi_n    = in_data;
          phase_n = PH_LO;
        end else begin
          decide = 1'b1;
        end
      end else begin
        case (phase_q)
          PH_LO:   decide = 1'b1;
          PH_CTL:  begin ctlv_n = 1'b1; phase_n = PH_INFO; end
          PH_INFO: infov_n = 1'b1;
          default: ;
        endcase
      end
    end
    if (decide) begin
      done_n  = 1'b1;
      acc_n   = sel_hit;
      pair_n  = sel_code;
      cr_n    = sel_hit && (cfg_two_byte ? hi_q[CR_BIT] : lo_hit[0]);
      auto_n  = (cfg_mode == 2'b00) && (sel_code == PAIR_SP1_T1);
      phase_n = sel_hit ? PH_CTL : PH_DROP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      hi_q    <= '0;
      done_q  <= 1'b0;
      acc_q   <= 1'b0;
      pair_q  <= PAIR_NONE;
      cr_q    <= 1'b0;
      auto_q  <= 1'b0;
      ctlv_q  <= 1'b0;
      infov_q <= 1'b0;
      dat_q   <= '0;
    end else begin
      phase_q <= phase_n;
      hi_q    <= hi_n;
      done_q  <= done_n;
      acc_q   <= acc_n;
      pair_q  <= pair_n;
      cr_q    <= cr_n;
      auto_q  <= auto_n;
      ctlv_q  <= ctlv_n;
      infov_q <= infov_n;
      dat_q   <= dat_n;
    end
  end

  assign st_done    = done_q;
  assign st_accept  = acc_q;
  assign st_pair    = pair_q;
  assign st_cr      = cr_q;
  assign st_auto    = auto_q;
  assign ctl_valid  = ctlv_q;
  assign ctl_data   = ctlv_q ? dat_q : '0;
  assign info_valid = infov_q;
  assign info_data  = infov_q ? dat_q : '0;
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
  parameter int W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_two_byte,
  input logic       cfg_mode_auto,
  input logic       in_valid,
  input logic       in_sof,
  input logic       st_done,
  input logic       st_accept,
  input logic [2:0] st_pair,
  input logic       st_cr,
  input logic       st_auto,
  input logic       ctl_valid,
  input logic       info_valid
);
  assert_pair_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_accept |-> (st_pair != 3'd0));

  assert_reject_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_accept |-> (st_pair == 3'd0 && !st_cr && !st_auto && !ctl_valid && !info_valid));

  assert_auto_only_sp1t1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_auto |-> (st_accept && st_pair == 3'd1));

  assert_one_byte_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !cfg_two_byte) |=> st_done);

  assert_two_byte_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && cfg_two_byte) |=> !st_done);

  assert_status_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done && !(in_valid && in_sof)) |=>
      (st_done && $stable(st_pair) && $stable(st_accept) && $stable(st_cr) && $stable(st_auto)));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_valid && info_valid));
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_two_byte(cfg_two_byte),
  .cfg_mode_auto(cfg_mode == 2'b00), .in_valid(in_valid), .in_sof(in_sof),
  .st_done(st_done), .st_accept(st_accept), .st_pair(st_pair), .st_cr(st_cr),
  .st_auto(st_auto), .ctl_valid(ctl_valid), .info_valid(info_valid)
);

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;
  logic       clk, rst_n;
  logic       cfg_two_byte, cfg_cr_ignore;
  logic [1:0] cfg_mode;
  logic [7:0] cfg_sp1, cfg_sp2, cfg_t1, cfg_t2;
  logic       in_valid, in_sof;
  logic [7:0] in_data;
  logic       st_done, st_accept, st_cr, st_auto, ctl_valid, info_valid;
  logic [2:0] st_pair;
  logic [7:0] ctl_data, info_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  hdlc_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_two_byte(cfg_two_byte), .cfg_cr_ignore(cfg_cr_ignore),
    .cfg_mode(cfg_mode), .cfg_sp1(cfg_sp1), .cfg_sp2(cfg_sp2), .cfg_t1(cfg_t1),
    .cfg_t2(cfg_t2), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .st_done(st_done), .st_accept(st_accept), .st_pair(st_pair), .st_cr(st_cr),
    .st_auto(st_auto), .ctl_valid(ctl_valid), .ctl_data(ctl_data),
    .info_valid(info_valid), .info_data(info_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic       two;
    logic       ign;
    logic [1:0] mode;
    logic [7:0] hi;
    logic [7:0] lo;
    logic       acc;
    logic [2:0] pair;
    logic       cr;
    logic       aut;
  } vec_t;

  // SP1=10 SP2=40 T1=03 T2=05; one-byte frames send only 'lo'.
  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'b00, 8'h10, 8'h03, 1'b1, 3'd1, 1'b0, 1'b1},
    '{1'b1, 1'b0, 2'b01, 8'h10, 8'h03, 1'b1, 3'd1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b10, 8'h10, 8'h03, 1'b1, 3'd1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'h10, 8'hFF, 1'b1, 3'd2, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'h10, 8'h05, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'h40, 8'h05, 1'b1, 3'd3, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'h40, 8'hFF, 1'b1, 3'd4, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'h40, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'hFC, 8'h03, 1'b1, 3'd5, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'hFC, 8'h05, 1'b1, 3'd5, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'hFC, 8'hFF, 1'b1, 3'd6, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'hFE, 8'hFF, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 2'b00, 8'hFE, 8'hFF, 1'b1, 3'd6, 1'b1, 1'b0},
    '{1'b1, 1'b1, 2'b00, 8'h12, 8'h03, 1'b1, 3'd1, 1'b1, 1'b1},
    '{1'b1, 1'b0, 2'b00, 8'h12, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'h20, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 2'b00, 8'h10, 8'h07, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'b00, 8'h00, 8'h03, 1'b1, 3'd7, 1'b1, 1'b0},
    '{1'b0, 1'b0, 2'b00, 8'h00, 8'h05, 1'b1, 3'd7, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'b00, 8'h00, 8'hFF, 1'b0, 3'd0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 2'b00, 8'h00, 8'h10, 1'b0, 3'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one byte for one cycle; returns just after the capturing edge.
  task automatic push(input logic sof, input logic [7:0] d);
    in_valid = 1'b1;
    in_sof   = sof;
    in_data  = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_data  = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic status(input string req, input logic acc, input logic [2:0] pair,
                        input logic cr, input logic aut);
    chk({req, " accept"}, st_accept, acc);
    chk({req, " pair"},   st_pair,   pair);
    chk({req, " cr"},     st_cr,     cr);
    chk({req, " auto"},   st_auto,   aut);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_two_byte = 1'b1; cfg_cr_ignore = 1'b0; cfg_mode = 2'b00;
    cfg_sp1 = 8'h10; cfg_sp2 = 8'h40; cfg_t1 = 8'h03; cfg_t2 = 8'h05;
    in_valid = 1'b0; in_sof = 1'b0; in_data = 8'h00;
    idle(3);
    // R13: reset state
    chk("R13 outputs in reset", {st_done, st_accept, st_pair, st_cr, st_auto, ctl_valid, info_valid}, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R13 outputs after reset", {st_done, st_accept, st_pair, st_cr, st_auto, ctl_valid, info_valid}, 0);

    // Table walk: R1..R9 under many address patterns
    for (int v = 0; v < NV; v++) begin
      cfg_two_byte  = VECS[v].two;
      cfg_cr_ignore = VECS[v].ign;
      cfg_mode      = VECS[v].mode;
      if (VECS[v].two) begin
        push(1'b1, VECS[v].hi);
        chk("R1/R10 no decision after high byte", st_done, 1'b0);
        push(1'b0, VECS[v].lo);
      end else begin
        push(1'b1, VECS[v].lo);
      end
      chk("R10 decision one cycle after address", st_done, 1'b1);
      status($sformatf("R4/R5/R6/R8 vec%0d", v), VECS[v].acc, VECS[v].pair, VECS[v].cr, VECS[v].aut);
      push(1'b0, 8'h3C);
      chk("R9/R7 ctl_valid", ctl_valid, VECS[v].acc);
      chk("R9 ctl_data", ctl_data, VECS[v].acc ? 8'h3C : 8'h00);
      chk("R9/R7 no info on ctl byte", info_valid, 1'b0);
      push(1'b0, 8'hA5);
      chk("R9/R7 info_valid", info_valid, VECS[v].acc);
      chk("R9 info_data", info_data, VECS[v].acc ? 8'hA5 : 8'h00);
      chk("R9 no ctl on info byte", ctl_valid, 1'b0);
      idle(1);
      chk("R9 strobes end with bytes", {ctl_valid, info_valid}, 2'b00);
    end

    // R2/R3: programmable values change the match (SP2=FC overlaps group -> SP2 wins)
    cfg_two_byte = 1'b1; cfg_cr_ignore = 1'b0; cfg_mode = 2'b00;
    cfg_sp2 = 8'hFC;
    push(1'b1, 8'hFC); push(1'b0, 8'h05);
    status("R2 SP2 equals group, priority", 1'b1, 3'd3, 1'b0, 1'b0);
    cfg_sp2 = 8'h40;
    cfg_t2 = 8'h77;
    push(1'b1, 8'h40); push(1'b0, 8'h77);
    status("R3 reprogrammed T2", 1'b1, 3'd3, 1'b0, 1'b0);
    cfg_t2 = 8'h05;

    // R6: T1 == T2 in one-byte mode resolves to command
    cfg_two_byte = 1'b0; cfg_t2 = 8'h03;
    push(1'b1, 8'h03);
    status("R6 T1 priority over T2", 1'b1, 3'd7, 1'b1, 1'b0);
    cfg_t2 = 8'h05;

    // R12: status holds through data bytes and idle cycles
    cfg_two_byte = 1'b1;
    push(1'b1, 8'h40); push(1'b0, 8'hFF);
    push(1'b0, 8'h11); push(1'b0, 8'h22); idle(4);
    status("R12 held after data and idle", 1'b1, 3'd4, 1'b0, 1'b0);
    chk("R12 done held", st_done, 1'b1);

    // R10/R11: short frame, then new frame restarts matching
    push(1'b1, 8'h10);
    chk("R11 sof clears status", {st_done, st_accept, st_pair}, 0);
    idle(3);
    chk("R10 short frame not decided", {st_done, st_accept}, 2'b00);
    push(1'b1, 8'h10); push(1'b0, 8'h03);
    status("R11 new frame after short one", 1'b1, 3'd1, 1'b0, 1'b1);

    // R11/R7: mid-frame sof with rejected address stops forwarding
    push(1'b0, 8'h3C);
    chk("R11 ctl before restart", ctl_valid, 1'b1);
    push(1'b1, 8'h20); push(1'b0, 8'h03);
    status("R11 restart rejected", 1'b0, 3'd0, 1'b0, 1'b0);
    push(1'b0, 8'h55);
    chk("R7 no ctl after reject", ctl_valid, 1'b0);
    push(1'b0, 8'h66);
    chk("R7 no info after reject", info_valid, 1'b0);

    // R1: mode switch to one-byte mid-stream; sof byte alone decides
    cfg_two_byte = 1'b0;
    push(1'b1, 8'h05);
    status("R1 one-byte decide on first byte", 1'b1, 3'd7, 1'b0, 1'b0);
    push(1'b0, 8'h10);
    chk("R1 second byte is control", ctl_valid, 1'b1);
    chk("R1 control data", ctl_data, 8'h10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule